// File: doc/BRIEF.md
# Bus Port Halt Chain

This block brings a set of bus master ports to a quiet state before the subsystem behind them is put into reset. One command walks through the ports one after another in a fixed order: index 0 is the processor port, index 1 the modem port, index 2 the non-coherent port. For each port the block first looks at the port's idle indication. A port that is already idle is passed over without any request. Any other port gets a halt request, and the block waits for the port's acknowledge for at most a set number of clock cycles.

When the wait ends, by acknowledge or by timeout, the idle indication is sampled again. A clear idle marks that port as failed. The request is then withdrawn; the port itself is expected to stay halted until the reset that follows. After the last port the block gives a one-cycle completion pulse together with one failure bit per port. The fabric and the reset that follows are outside this block.

Top module: `bus_halt_chain`

## Requirements
- R1: While and just after reset, `halt_req` is all zero, `halt_done` and `busy` are low and `halt_fail` is zero.
- R2: Ports are handled strictly in index order (0 processor, 1 modem, 2 non-coherent), and at most one bit of `halt_req` is high in any cycle.
- R3: A port whose `port_idle` bit is high when its turn starts never sees its request bit rise and costs 2 cycles, so with every port idle `halt_done` rises 2*NUM_PORTS cycles after the edge that samples `halt_cmd`.
- R4: A requested port keeps its request high until its `port_ack` bit is seen at a clock edge; the request drops at that edge, so a port that acknowledges D cycles after its request rises costs D+2 cycles.
- R5: A port that never acknowledges has its request held for exactly TIMEOUT_CYC cycles and costs TIMEOUT_CYC+2 cycles.
- R6: The failure bit of a requested port equals the inverse of its `port_idle` bit at the edge where the wait ends; an acknowledge without idle sets it, and idle reached before a timeout clears it.
- R7: `halt_done` is high for exactly one cycle per command; `halt_fail` bit i reports port i, is valid with `halt_done` and holds its value until the next completion.
- R8: A `halt_cmd` pulse that arrives while `busy` is high is ignored: it neither restarts the walk nor yields a second completion.
- R9: Each port's request rises at most once per command and stays low after being withdrawn, even though the port keeps its acknowledge high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_cmd | input | 1 | Start pulse; taken only while not busy |
| port_ack | input | NUM_PORTS | Halt acknowledge from each port |
| port_idle | input | NUM_PORTS | Idle indication from each port |
| halt_req | output | NUM_PORTS | Halt request to each port |
| halt_done | output | 1 | One-cycle completion pulse |
| halt_fail | output | NUM_PORTS | Per-port failure flags, valid with `halt_done` |
| busy | output | 1 | High while the walk through the ports is in progress |

## Verification
The bound checker watches on every cycle that requests are never raised on two ports at once, that an observed acknowledge removes every request at the next edge, that no request stays high longer than the timeout, that completion is a single-cycle pulse ending each busy period, and that the failure flags only move with completion. Exact latencies, the skip of already-idle ports, the order of requests, the failure bit under the separate acknowledge and idle combinations, and the ignoring of a command given during a walk can only be shown by the bench's scenarios, which drive port models with chosen acknowledge delays and idle behaviour.

// File: rtl/halt_chain_pkg.sv
package halt_chain_pkg;

  typedef enum logic {
    UNIT_READY = 1'b0,
    UNIT_WAIT  = 1'b1
  } unit_state_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  function automatic int ptr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/halt_wait_timer.sv
module halt_wait_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
    end else if (en) begin
      count_q <= count_q + CW'(1);
    end
  end

  // High on the last cycle of a LIMIT-cycle wait window.
  assign expired = en && (count_q == CW'(LIMIT - 1));
endmodule

// File: rtl/halt_port_unit.sv
module halt_port_unit
  import halt_chain_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic port_ack,
  input  logic port_idle,
  output logic halt_req,
  output logic unit_done,
  output logic unit_fail
);
  unit_state_t state_q;
  logic        wait_over;

  halt_wait_timer #(
    .LIMIT(TIMEOUT_CYC)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (state_q == UNIT_READY),
    .en     (state_q == UNIT_WAIT),
    .expired(wait_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= UNIT_READY;
      halt_req  <= 1'b0;
      unit_done <= 1'b0;
      unit_fail <= 1'b0;
    end else begin
      unit_done <= 1'b0;
      case (state_q)
        UNIT_READY: begin
          if (start) begin
            if (port_idle) begin
              // Already quiet: finish without raising a request.
              unit_done <= 1'b1;
              unit_fail <= 1'b0;
            end else begin
              halt_req <= 1'b1;
              state_q  <= UNIT_WAIT;
            end
          end
        end
        UNIT_WAIT: begin
          if (port_ack || wait_over) begin
            // Idle is judged on its own, not inferred from ack.
            halt_req  <= 1'b0;
            unit_done <= 1'b1;
            unit_fail <= ~port_idle;
            state_q   <= UNIT_READY;
          end
        end
        default: state_q <= UNIT_READY;
      endcase
    end
  end
endmodule

// File: rtl/halt_sequencer.sv
module halt_sequencer
  import halt_chain_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd,
  input  logic [NUM_PORTS-1:0] unit_done,
  input  logic [NUM_PORTS-1:0] unit_fail,
  output logic [NUM_PORTS-1:0] unit_start,
  output logic                 seq_done,
  output logic [NUM_PORTS-1:0] seq_fail,
  output logic                 busy
);
  localparam int PW = ptr_width(NUM_PORTS);

  seq_state_t           state_q;
  logic [PW-1:0]        ptr_q;
  logic [PW-1:0]        ptr_nxt;
  logic [NUM_PORTS-1:0] acc_q;
  logic [NUM_PORTS-1:0] acc_nxt;

  assign ptr_nxt = ptr_q + PW'(1);

  always_comb begin
    acc_nxt        = acc_q;
    acc_nxt[ptr_q] = unit_fail[ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      ptr_q      <= '0;
      acc_q      <= '0;
      unit_start <= '0;
      seq_done   <= 1'b0;
      seq_fail   <= '0;
    end else begin
      unit_start <= '0;
      seq_done   <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (cmd) begin
            ptr_q         <= '0;
            acc_q         <= '0;
            unit_start[0] <= 1'b1;
            state_q       <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (unit_done[ptr_q]) begin
            acc_q <= acc_nxt;
            if (ptr_q == PW'(NUM_PORTS - 1)) begin
              seq_done <= 1'b1;
              seq_fail <= acc_nxt;
              state_q  <= SEQ_IDLE;
            end else begin
              ptr_q               <= ptr_nxt;
              unit_start[ptr_nxt] <= 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state_q == SEQ_RUN);
endmodule

// File: rtl/bus_halt_chain.sv
module bus_halt_chain #(
  parameter int NUM_PORTS   = 3,
  parameter int TIMEOUT_CYC = 10_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 halt_cmd,
  input  logic [NUM_PORTS-1:0] port_ack,
  input  logic [NUM_PORTS-1:0] port_idle,
  output logic [NUM_PORTS-1:0] halt_req,
  output logic                 halt_done,
  output logic [NUM_PORTS-1:0] halt_fail,
  output logic                 busy
);
  logic [NUM_PORTS-1:0] start_v;
  logic [NUM_PORTS-1:0] done_v;
  logic [NUM_PORTS-1:0] fail_v;

  halt_sequencer #(
    .NUM_PORTS(NUM_PORTS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd       (halt_cmd),
    .unit_done (done_v),
    .unit_fail (fail_v),
    .unit_start(start_v),
    .seq_done  (halt_done),
    .seq_fail  (halt_fail),
    .busy      (busy)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    halt_port_unit #(
      .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_unit (
      .clk      (clk),
      .rst      (rst),
      .start    (start_v[g]),
      .port_ack (port_ack[g]),
      .port_idle(port_idle[g]),
      .halt_req (halt_req[g]),
      .unit_done(done_v[g]),
      .unit_fail(fail_v[g])
    );
  end
endmodule

// File: rtl/halt_chain_checker.sv
module halt_chain_checker #(
  parameter int NUM_PORTS   = 3,
  parameter int TIMEOUT_CYC = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 halt_cmd,
  input logic [NUM_PORTS-1:0] port_ack,
  input logic [NUM_PORTS-1:0] port_idle,
  input logic [NUM_PORTS-1:0] halt_req,
  input logic                 halt_done,
  input logic [NUM_PORTS-1:0] halt_fail,
  input logic                 busy
);
  localparam int HW = $clog2(TIMEOUT_CYC + 2);

  logic [HW-1:0] held_q;

  // Counts consecutive edges with a request raised.
  always_ff @(posedge clk) begin
    if (rst || (halt_req == '0)) held_q <= '0;
    else if (held_q != {HW{1'b1}}) held_q <= held_q + HW'(1);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (halt_req == '0 && !halt_done && !busy && halt_fail == '0));

  assert_one_request_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(halt_req));

  assert_walk_ends_done_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> halt_done);

  assert_ack_drops_req_R4: assert property (@(posedge clk) disable iff (rst)
    (|(halt_req & port_ack)) |=> (halt_req == '0));

  assert_req_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    held_q <= HW'(TIMEOUT_CYC));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    halt_done |=> !halt_done);

  assert_fail_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !halt_done |-> $stable(halt_fail));

  assert_no_req_when_free_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (halt_req == '0));
endmodule

bind bus_halt_chain halt_chain_checker #(
  .NUM_PORTS  (NUM_PORTS),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .halt_cmd (halt_cmd),
  .port_ack (port_ack),
  .port_idle(port_idle),
  .halt_req (halt_req),
  .halt_done(halt_done),
  .halt_fail(halt_fail),
  .busy     (busy)
);

// File: tb/bus_halt_chain_bench.sv
module bus_halt_chain_bench;
  localparam int NP = 3;
  localparam int TO = 16;

  // Port model behaviours
  localparam int M_IDLE   = 0; // idle from the start
  localparam int M_ACK    = 1; // ack after d cycles, idle with it
  localparam int M_NOIDLE = 2; // ack after d cycles, never idle
  localparam int M_LATE   = 3; // no ack, idle after d cycles
  localparam int M_DEAD   = 4; // neither

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          halt_cmd = 1'b0;
  logic [NP-1:0] port_ack = '0;
  logic [NP-1:0] port_idle = '0;
  logic [NP-1:0] halt_req;
  logic          halt_done;
  logic [NP-1:0] halt_fail;
  logic          busy;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic clr = 1'b0;
  int mode [NP];
  int dly  [NP];
  int cnt  [NP];
  int hi   [NP];
  int rises[NP];
  int rcyc [NP];
  logic got[NP];
  logic prv[NP];
  int done_cnt = 0;

  bus_halt_chain #(.NUM_PORTS(NP), .TIMEOUT_CYC(TO)) u_bus_halt_chain (
    .clk(clk), .rst(rst), .halt_cmd(halt_cmd), .port_ack(port_ack),
    .port_idle(port_idle), .halt_req(halt_req), .halt_done(halt_done),
    .halt_fail(halt_fail), .busy(busy));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Port models and monitors, all on the falling edge.
  always @(negedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (clr) begin
        cnt[i] = 0; hi[i] = 0; rises[i] = 0; rcyc[i] = 0;
        got[i] = 1'b0; prv[i] = 1'b0;
      end else begin
        if (halt_req[i]) begin
          cnt[i] = cnt[i] + 1;
          hi[i]  = hi[i] + 1;
          if (!prv[i]) begin rises[i] = rises[i] + 1; rcyc[i] = cyc; end
        end
        prv[i] = halt_req[i];
        if ((mode[i] == M_ACK || mode[i] == M_NOIDLE) && cnt[i] >= dly[i] && cnt[i] > 0)
          got[i] = 1'b1;
      end
      port_ack[i] <= got[i];
      case (mode[i])
        M_IDLE:  port_idle[i] <= 1'b1;
        M_ACK:   port_idle[i] <= got[i];
        M_LATE:  port_idle[i] <= (cnt[i] >= dly[i]);
        default: port_idle[i] <= 1'b0;
      endcase
    end
    if (clr) done_cnt = 0;
    else if (halt_done) done_cnt = done_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setup(input int m0, input int d0, input int m1, input int d1,
                       input int m2, input int d2);
    mode[0] = m0; dly[0] = d0; mode[1] = m1; dly[1] = d1;
    mode[2] = m2; dly[2] = d2;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
  endtask

  // Fires a command, optionally repeats it at step 'again', returns latency.
  task automatic fire(input int again, output int lat);
    int cmd_cyc;
    int n;
    halt_cmd = 1'b1;
    cmd_cyc = cyc + 1;
    n = 0;
    lat = -1;
    while (n < 2000) begin
      @(negedge clk);
      n++;
      halt_cmd = (again != 0 && n == again);
      if (halt_done) begin lat = cyc - cmd_cyc; break; end
    end
    halt_cmd = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 req", int'(halt_req), 0);
    chk("R1 done", int'(halt_done), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 fail", int'(halt_fail), 0);
  endtask

  task automatic t_all_idle;
    int lat;
    setup(M_IDLE, 0, M_IDLE, 0, M_IDLE, 0);
    fire(0, lat);
    chk("R3 latency all idle", lat, 2 * NP);
    chk("R3 no request raised", rises[0] + rises[1] + rises[2], 0);
    chk("R6 fail all idle", int'(halt_fail), 0);
    chk("R7 single done", done_cnt, 1);
  endtask

  task automatic t_all_ack;
    int lat;
    setup(M_ACK, 2, M_ACK, 3, M_ACK, 1);
    fire(0, lat);
    chk("R4 latency acked", lat, 4 + 5 + 3);
    chk("R4 hold p0", hi[0], 2);
    chk("R4 hold p1", hi[1], 3);
    chk("R4 hold p2", hi[2], 1);
    chk("R2 order 0<1", int'(rcyc[1] > rcyc[0]), 1);
    chk("R2 order 1<2", int'(rcyc[2] > rcyc[1]), 1);
    chk("R9 rises p0", rises[0], 1);
    chk("R9 rises p2", rises[2], 1);
    chk("R6 fail acked", int'(halt_fail), 0);
  endtask

  task automatic t_ack_no_idle;
    int lat;
    setup(M_IDLE, 0, M_NOIDLE, 2, M_ACK, 1);
    fire(0, lat);
    chk("R3 R4 latency mixed", lat, 2 + 4 + 3);
    chk("R3 skipped p0", rises[0], 0);
    chk("R6 ack without idle", int'(halt_fail), 3'b010);
  endtask

  task automatic t_timeout;
    int lat;
    setup(M_DEAD, 0, M_LATE, 5, M_IDLE, 0);
    fire(0, lat);
    chk("R5 latency timeouts", lat, (TO + 2) * 2 + 2);
    chk("R5 hold p0", hi[0], TO);
    chk("R5 hold p1", hi[1], TO);
    chk("R6 timeout fail bits", int'(halt_fail), 3'b001);
    repeat (5) @(negedge clk);
    chk("R7 fail held", int'(halt_fail), 3'b001);
  endtask

  task automatic t_busy_cmd;
    int lat;
    setup(M_ACK, 4, M_ACK, 4, M_ACK, 4);
    fire(3, lat);
    chk("R8 latency unchanged", lat, 18);
    chk("R8 one completion", done_cnt, 1);
    chk("R8 p0 requested once", rises[0], 1);
    chk("R9 p1 requested once", rises[1], 1);
    chk("R8 no request after", int'(halt_req), 0);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin mode[i] = M_DEAD; dly[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_all_idle();
    t_all_ack();
    t_ack_no_idle();
    t_timeout();
    t_busy_cmd();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule